// File: doc/BRIEF.md
# Deadline-Aware Two-Master Write Bus Arbiter

This block decides which of two masters drives a shared memory write bus. One master carries a real-time stream that owes a fixed number of beats in every frame period. The other is a bulk master with no deadline. When both ask for the bus at the same boundary, the real-time side wins. A burst that has started is never interrupted. Each granted burst moves one beat per cycle, and the arbiter marks the beat that ends the burst.

Worst-case blocking of the real-time master is kept short by a cap on every bulk burst. A bulk request that is longer than the cap is served as a chain of capped bursts, and arbitration runs again at each link, so the real-time side can cut in between them. Each master presents the number of beats it still needs, and lowers that number as it sees its beats granted.

A frame pulse starts each period and reloads the real-time quota. If the real-time master has not moved its whole quota by the next pulse, a sticky deadline flag is raised. The flag stays set until reset.

Top module: `rt_bus_arbiter`

## Requirements
- R1: When both masters present a valid request (request high, length non-zero) at a burst boundary, the next burst goes to the real-time master.
- R2: A burst is non-preemptive. While a beat that is not the last is on the bus, the next cycle keeps the same grant and beat_valid stays high, even if the real-time master starts requesting.
- R3: A bulk burst lasts min(be_len, BE_CAP) beats, with be_len sampled at its grant. A longer request is served as consecutive capped bursts with arbitration between them.
- R4: A real-time burst lasts exactly rt_len beats, sampled at its grant. This length is not capped.
- R5: If the bus is idle and one master has a valid request, that master is granted in the next cycle. A valid request present during a last beat starts its burst in the very next cycle, with no idle cycle between.
- R6: A real-time master that keeps a valid request waits at most BE_CAP cycles without a grant.
- R7: deadline_miss becomes 1 one cycle after a frame_start cycle in which real-time beats are still owed, counting any real-time beat on the bus in that same cycle as done. Each frame_start reloads the quota to FRAME_BEATS. The quota is 0 after reset, so the first pulse cannot flag. The flag stays at 1 until reset.
- R8: In reset, and in the first cycle after it, rt_gnt, be_gnt, beat_valid, beat_last and deadline_miss are all 0.
- R9: A request with length 0 is ignored. If no valid request is present at a boundary, the bus goes idle.
- R10: At most one grant is high at a time. beat_valid is high exactly when a grant is high, and beat_last marks the final beat of each burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| frame_start | input | 1 | One-cycle pulse that opens a new frame period |
| rt_req | input | 1 | Real-time master requests the bus |
| rt_len | input | LEN_W | Beats the real-time master still needs |
| rt_gnt | output | 1 | Current beat belongs to the real-time master |
| be_req | input | 1 | Bulk master requests the bus |
| be_len | input | LEN_W | Beats the bulk master still needs |
| be_gnt | output | 1 | Current beat belongs to the bulk master |
| beat_valid | output | 1 | A beat is on the bus this cycle |
| beat_last | output | 1 | This beat ends the current burst |
| deadline_miss | output | 1 | Sticky flag: a frame ended with real-time beats owed |

## Verification
The assertions watch these rules on every cycle:
- the tie-break at each boundary;
- that the grant holds through the middle of a burst;
- the bulk burst cap;
- the bound on how long the real-time master waits;
- that a single requester on an idle bus is granted at once;
- grant exclusivity;
- that the deadline flag only rises after a frame pulse and never falls.

Only the directed scenarios can show the exact burst lengths produced by splitting, the order in which a real-time burst slots in between capped bulk bursts, and the uncapped real-time length. The scenarios also cover the frame-boundary corner in which the final owed beat and the frame pulse share a cycle.

// File: rtl/rtarb_pkg.sv
package rtarb_pkg;
  typedef enum logic [1:0] {
    OWN_NONE = 2'd0,
    OWN_RT   = 2'd1,
    OWN_BE   = 2'd2
  } owner_e;
endpackage

// File: rtl/rtarb_pick.sv
module rtarb_pick
  import rtarb_pkg::*;
#(
  parameter int LEN_W  = 6,
  parameter int BE_CAP = 4
) (
  input  logic             rt_req,
  input  logic [LEN_W-1:0] rt_len,
  input  logic             be_req,
  input  logic [LEN_W-1:0] be_len,
  output owner_e           pick,
  output logic [LEN_W-1:0] pick_len
);
  localparam logic [LEN_W-1:0] CAP_V = BE_CAP[LEN_W-1:0];

  logic             rt_ok;
  logic             be_ok;
  logic [LEN_W-1:0] be_trim;

  assign rt_ok   = rt_req && (rt_len != '0);
  assign be_ok   = be_req && (be_len != '0);
  assign be_trim = (be_len > CAP_V) ? CAP_V : be_len;

  // fixed priority: the real-time side wins every tie
  always_comb begin
    pick     = OWN_NONE;
    pick_len = '0;
    if (rt_ok) begin
      pick     = OWN_RT;
      pick_len = rt_len;
    end else if (be_ok) begin
      pick     = OWN_BE;
      pick_len = be_trim;
    end
  end
endmodule

// File: rtl/rtarb_burst.sv
module rtarb_burst
  import rtarb_pkg::*;
#(
  parameter int LEN_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  owner_e           pick,
  input  logic [LEN_W-1:0] pick_len,
  output logic             rt_gnt,
  output logic             be_gnt,
  output logic             beat_valid,
  output logic             beat_last
);
  localparam logic [LEN_W-1:0] ONE_V = LEN_W'(1);
  localparam logic [LEN_W-1:0] TWO_V = LEN_W'(2);

  logic [LEN_W-1:0] left_q;
  logic             boundary;

  // a new owner is chosen only when idle or on the final beat
  assign boundary = !beat_valid || beat_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      rt_gnt     <= 1'b0;
      be_gnt     <= 1'b0;
      beat_valid <= 1'b0;
      beat_last  <= 1'b0;
      left_q     <= '0;
    end else if (boundary) begin
      rt_gnt     <= (pick == OWN_RT);
      be_gnt     <= (pick == OWN_BE);
      beat_valid <= (pick != OWN_NONE);
      beat_last  <= (pick != OWN_NONE) && (pick_len == ONE_V);
      left_q     <= pick_len;
    end else begin
      left_q     <= left_q - ONE_V;
      beat_last  <= (left_q == TWO_V);
    end
  end
endmodule

// File: rtl/rtarb_quota.sv
module rtarb_quota #(
  parameter int FRAME_BEATS = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic frame_start,
  input  logic rt_beat,
  output logic deadline_miss
);
  localparam int OWE_W = $clog2(FRAME_BEATS + 1);
  localparam logic [OWE_W-1:0] QUOTA_V = OWE_W'(FRAME_BEATS);

  logic [OWE_W-1:0] owed_q;
  logic [OWE_W-1:0] owed_nx;

  // the beat on the bus this cycle counts before the frame check
  assign owed_nx = (rt_beat && (owed_q != '0)) ? owed_q - OWE_W'(1) : owed_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      owed_q        <= '0;
      deadline_miss <= 1'b0;
    end else if (frame_start) begin
      deadline_miss <= deadline_miss || (owed_nx != '0);
      owed_q        <= QUOTA_V;
    end else begin
      owed_q        <= owed_nx;
    end
  end
endmodule

// File: rtl/rt_bus_arbiter.sv
module rt_bus_arbiter
  import rtarb_pkg::*;
#(
  parameter int LEN_W       = 6,
  parameter int BE_CAP      = 4,
  parameter int FRAME_BEATS = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             frame_start,
  input  logic             rt_req,
  input  logic [LEN_W-1:0] rt_len,
  output logic             rt_gnt,
  input  logic             be_req,
  input  logic [LEN_W-1:0] be_len,
  output logic             be_gnt,
  output logic             beat_valid,
  output logic             beat_last,
  output logic             deadline_miss
);
  owner_e           pick;
  logic [LEN_W-1:0] pick_len;

  rtarb_pick #(.LEN_W(LEN_W), .BE_CAP(BE_CAP)) u_pick (
    .rt_req   (rt_req),
    .rt_len   (rt_len),
    .be_req   (be_req),
    .be_len   (be_len),
    .pick     (pick),
    .pick_len (pick_len)
  );

  rtarb_burst #(.LEN_W(LEN_W)) u_burst (
    .clk        (clk),
    .rst        (rst),
    .pick       (pick),
    .pick_len   (pick_len),
    .rt_gnt     (rt_gnt),
    .be_gnt     (be_gnt),
    .beat_valid (beat_valid),
    .beat_last  (beat_last)
  );

  rtarb_quota #(.FRAME_BEATS(FRAME_BEATS)) u_quota (
    .clk           (clk),
    .rst           (rst),
    .frame_start   (frame_start),
    .rt_beat       (rt_gnt && beat_valid),
    .deadline_miss (deadline_miss)
  );
endmodule

// File: rtl/rtarb_chk.sv
module rtarb_chk #(
  parameter int LEN_W  = 6,
  parameter int BE_CAP = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             frame_start,
  input logic             rt_req,
  input logic [LEN_W-1:0] rt_len,
  input logic             rt_gnt,
  input logic             be_req,
  input logic [LEN_W-1:0] be_len,
  input logic             be_gnt,
  input logic             beat_valid,
  input logic             beat_last,
  input logic             deadline_miss
);
  localparam int CW = LEN_W + 2;
  localparam logic [CW-1:0] CAP_C = CW'(BE_CAP);

  logic          rt_ok, be_ok, bnd;
  logic [CW-1:0] be_run;
  logic [CW-1:0] rt_wait;

  assign rt_ok = rt_req && (rt_len != '0);
  assign be_ok = be_req && (be_len != '0);
  assign bnd   = !beat_valid || beat_last;

  always_ff @(posedge clk) begin
    if (rst) begin
      be_run  <= '0;
      rt_wait <= '0;
    end else begin
      if (be_gnt && beat_valid && !beat_last) be_run <= be_run + CW'(1);
      else                                    be_run <= '0;
      if (rt_ok && !rt_gnt) begin
        if (rt_wait != '1) rt_wait <= rt_wait + CW'(1);
      end else begin
        rt_wait <= '0;
      end
    end
  end

  assert_tie_rt_R1: assert property (@(posedge clk) disable iff (rst)
    (bnd && rt_ok && be_ok) |=> rt_gnt);

  assert_hold_burst_R2: assert property (@(posedge clk) disable iff (rst)
    (beat_valid && !beat_last) |=> (beat_valid && $stable(rt_gnt) && $stable(be_gnt)));

  assert_be_cap_R3: assert property (@(posedge clk) disable iff (rst)
    (be_gnt && beat_valid) |-> (be_run < CAP_C));

  assert_idle_grant_R5: assert property (@(posedge clk) disable iff (rst)
    (!beat_valid && be_ok && !rt_ok) |=> be_gnt);

  assert_rt_wait_R6: assert property (@(posedge clk) disable iff (rst)
    rt_wait <= CAP_C);

  assert_miss_cause_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(deadline_miss) |-> $past(frame_start));

  assert_miss_sticky_R7: assert property (@(posedge clk) disable iff (rst)
    deadline_miss |=> deadline_miss);

  assert_no_req_idle_R9: assert property (@(posedge clk) disable iff (rst)
    (bnd && !rt_ok && !be_ok) |=> !beat_valid);

  assert_excl_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rt_gnt, be_gnt}) && (beat_valid == (rt_gnt || be_gnt)));
endmodule

bind rt_bus_arbiter rtarb_chk #(.LEN_W(LEN_W), .BE_CAP(BE_CAP)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .frame_start   (frame_start),
  .rt_req        (rt_req),
  .rt_len        (rt_len),
  .rt_gnt        (rt_gnt),
  .be_req        (be_req),
  .be_len        (be_len),
  .be_gnt        (be_gnt),
  .beat_valid    (beat_valid),
  .beat_last     (beat_last),
  .deadline_miss (deadline_miss)
);

// File: tb/sim_rt_bus_arbiter.sv
module sim_rt_bus_arbiter;
  localparam int CLK_P  = 10;
  localparam int LEN_W  = 6;
  localparam int BE_CAP = 4;
  localparam int FRAME  = 16;

  logic clk = 1'b0;
  logic rst, frame_start, rt_req, be_req;
  logic [LEN_W-1:0] rt_len, be_len;
  logic rt_gnt, be_gnt, beat_valid, beat_last, deadline_miss;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  rt_bus_arbiter #(.LEN_W(LEN_W), .BE_CAP(BE_CAP), .FRAME_BEATS(FRAME)) u0 (
    .clk(clk), .rst(rst), .frame_start(frame_start),
    .rt_req(rt_req), .rt_len(rt_len), .rt_gnt(rt_gnt),
    .be_req(be_req), .be_len(be_len), .be_gnt(be_gnt),
    .beat_valid(beat_valid), .beat_last(beat_last),
    .deadline_miss(deadline_miss)
  );

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // compares {rt_gnt, be_gnt, beat_valid, beat_last}
  task automatic expect_bus(input bit r, input bit b, input bit v, input bit l, input string tag);
    logic [3:0] act, exp;
    act = {rt_gnt, be_gnt, beat_valid, beat_last};
    exp = {r, b, v, l};
    chk(act === exp, tag, int'(act), int'(exp));
  endtask

  task automatic burst(input bit is_rt, input int n, input string tag);
    for (int i = 1; i <= n; i++) begin
      tick();
      expect_bus(is_rt, !is_rt, 1'b1, i == n, tag);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; frame_start = 1'b0;
    rt_req = 1'b0; be_req = 1'b0; rt_len = '0; be_len = '0;
    repeat (2) tick();
    rst = 1'b0;
  endtask

  task automatic t_reset();
    do_reset();
    expect_bus(0, 0, 0, 0, "R8 outputs in reset");
    chk(deadline_miss === 1'b0, "R8 miss in reset", int'(deadline_miss), 0);
    tick();
    expect_bus(0, 0, 0, 0, "R8 idle after reset");
  endtask

  task automatic t_idle_single();
    be_req = 1'b1; be_len = 6'd3;
    burst(0, 3, "R5 single bulk requester");
    be_req = 1'b0;
    tick();
    expect_bus(0, 0, 0, 0, "R9 idle after drop");
  endtask

  task automatic t_tie();
    rt_req = 1'b1; rt_len = 6'd2; be_req = 1'b1; be_len = 6'd2;
    burst(1, 2, "R1 tie goes real-time");
    rt_req = 1'b0;
    burst(0, 2, "R5 bulk follows back-to-back");
    be_req = 1'b0;
    tick();
    expect_bus(0, 0, 0, 0, "R1 idle at end");
  endtask

  task automatic t_split();
    be_req = 1'b1; be_len = 6'd10;
    burst(0, 4, "R3 first capped burst");
    be_len = 6'd6;
    burst(0, 4, "R3 second capped burst");
    be_len = 6'd2;
    burst(0, 2, "R3 remainder burst");
    be_req = 1'b0;
    tick();
    expect_bus(0, 0, 0, 0, "R3 idle at end");
  endtask

  task automatic t_cut_in();
    be_req = 1'b1; be_len = 6'd10;
    tick();
    expect_bus(0, 1, 1, 0, "R2 bulk beat 1");
    rt_req = 1'b1; rt_len = 6'd3;
    tick(); expect_bus(0, 1, 1, 0, "R2 no preempt beat 2");
    tick(); expect_bus(0, 1, 1, 0, "R2 no preempt beat 3");
    tick(); expect_bus(0, 1, 1, 1, "R2 bulk ends at cap");
    be_len = 6'd6;
    burst(1, 3, "R6 real-time cuts in between splits");
    rt_req = 1'b0;
    burst(0, 4, "R3 bulk resumes capped");
    be_len = 6'd2;
    burst(0, 2, "R3 bulk tail");
    be_req = 1'b0;
    tick();
    expect_bus(0, 0, 0, 0, "R2 idle at end");
  endtask

  task automatic t_rt_long();
    rt_req = 1'b1; rt_len = 6'd10;
    burst(1, 10, "R4 real-time burst uncapped");
    rt_req = 1'b0;
    tick();
    expect_bus(0, 0, 0, 0, "R4 idle at end");
  endtask

  task automatic t_zero();
    be_req = 1'b1; be_len = '0;
    tick(); expect_bus(0, 0, 0, 0, "R9 zero-length bulk ignored");
    tick(); expect_bus(0, 0, 0, 0, "R9 zero-length bulk still ignored");
    rt_req = 1'b1; rt_len = '0; be_len = 6'd2;
    burst(0, 2, "R9 zero-length real-time loses");
    rt_req = 1'b0; be_req = 1'b0;
    tick();
    expect_bus(0, 0, 0, 0, "R9 idle at end");
  endtask

  task automatic t_deadline();
    do_reset();
    frame_start = 1'b1; tick(); frame_start = 1'b0;
    chk(deadline_miss === 1'b0, "R7 first frame no miss", int'(deadline_miss), 0);
    rt_req = 1'b1; rt_len = 6'(FRAME);
    burst(1, FRAME, "R7 quota burst");
    rt_req = 1'b0;
    // last owed beat shares the cycle with the pulse
    frame_start = 1'b1; tick(); frame_start = 1'b0;
    chk(deadline_miss === 1'b0, "R7 quota met no miss", int'(deadline_miss), 0);
    tick();
    chk(deadline_miss === 1'b0, "R7 still no miss", int'(deadline_miss), 0);
    frame_start = 1'b1; tick(); frame_start = 1'b0;
    chk(deadline_miss === 1'b1, "R7 unpaid frame flags", int'(deadline_miss), 1);
    repeat (3) tick();
    chk(deadline_miss === 1'b1, "R7 flag sticky", int'(deadline_miss), 1);
    do_reset();
    chk(deadline_miss === 1'b0, "R8 reset clears flag", int'(deadline_miss), 0);
  endtask

  initial begin
    #(CLK_P * 100000);
    checks++; fails++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    t_reset();
    t_idle_single();
    t_tie();
    t_split();
    t_cut_in();
    t_rt_long();
    t_zero();
    t_deadline();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule